// File: doc/BRIEF.md
# Cascadable Delay-Setting Register

This block holds the binary setting of a programmable delay element and offers two ways to load it. With the mode input high, the setting comes from a parallel bus. While the enable is high the register follows the bus, and when the enable drops the register holds the last value it saw. With the mode input low, the setting is reached through a serial shift chain. The chain has a data input, a data output, a shift clock and the same enable. The data output of one unit can drive the data input of the next, so any number of units form one long chain.

All pins are sampled on the system clock `clk`. The shift clock is a plain input, and its rising transitions are found by comparing it with its value one cycle earlier. During a serial access the applied delay code does not move. The shifted contents become the new code on the cycle after the enable falls. A serial read pushes the incoming bits into the chain, so it destroys the old setting. To keep a setting, feed the bits being read back into the chain during the same access.

Top module: `dly_setting_reg`

## Requirements
- R1: A synchronous active-high `rst` clears `dly_code` to zero and drives `ser_out` low on the following clock edge.
- R2: With `mode_par`=1 and `enable`=1, `dly_code` equals the `par_in` value sampled at the previous clock edge.
- R3: With `mode_par`=1 and `enable`=0, `dly_code` keeps the `par_in` value of the last cycle in which `enable` was high; later changes on `par_in` have no effect.
- R4: With `mode_par`=0, `ser_out` shows bit W-1 (the MSB) of the stored setting from the first cycle `enable` is high, before any shift.
- R5: Each rising transition of `ser_clk` seen while `mode_par`=0 and `enable`=1 shifts the chain one place toward the MSB. `ser_in` enters at bit 0, and `ser_out` shows the next lower bit one cycle later. After W shifts, the first bit sent sits in the MSB.
- R6: `dly_code` stays constant while a serial access is open. On the cycle after `enable` falls with `mode_par`=0, it takes the shifted chain contents.
- R7: A serial read is destructive. After W shifts of zeros, the committed code is zero. Bits from `ser_out` fed back into `ser_in` during the same access restore the original code.
- R8: In a chain of N units, a stream of 8·N bits sent MSB first leaves its first byte in the unit farthest from the stream source. Reading the far unit's `ser_out` returns the old settings, far unit first.
- R9: `ser_clk` transitions while `enable`=0 change neither `dly_code` nor `ser_out`.
- R10: With `mode_par`=0 and `enable`=0, `ser_out` equals the MSB of `dly_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | 1 = parallel loading, 0 = serial chain |
| enable | input | 1 | Transparency control in parallel mode, access window in serial mode |
| par_in | input | W | Parallel setting value |
| ser_in | input | 1 | Serial data into bit 0 of the chain |
| ser_clk | input | 1 | Shift clock; its rising transitions shift the chain |
| ser_out | output | 1 | MSB of the chain, for readback or for the next unit |
| dly_code | output | W | Setting applied to the delay element |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `mode_par` is stable during a serial access. The bench satisfies both: it changes inputs only on the falling clock edge, and it sets the mode before raising `enable`. It holds each level of the shift clock for at least one full clock cycle, so each rising transition is seen exactly once. It also waits a cycle after dropping `enable` before it reads the committed code.

// File: rtl/dly_set_pkg.sv
package dly_set_pkg;
  localparam int unsigned DEFAULT_WIDTH = 8;

  typedef enum logic [1:0] {
    ACC_HOLD     = 2'd0,
    ACC_PAR_OPEN = 2'd1,
    ACC_SER_OPEN = 2'd2,
    ACC_SER_DONE = 2'd3
  } access_e;
endpackage

// File: rtl/dly_prev_bit.sv
module dly_prev_bit (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/dly_code_store.sv
module dly_code_store
  import dly_set_pkg::*;
#(
  parameter int unsigned W = DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  access_e      acc,
  input  logic [W-1:0] par_val,
  input  logic [W-1:0] chain_val,
  output logic [W-1:0] code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else begin
      unique case (acc)
        ACC_PAR_OPEN: code <= par_val;
        ACC_SER_DONE: code <= chain_val;
        default:      code <= code;
      endcase
    end
  end
endmodule

// File: rtl/dly_shift_chain.sv
module dly_shift_chain
  import dly_set_pkg::*;
#(
  parameter int unsigned W = DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  access_e      acc,
  input  logic         step,
  input  logic         sin,
  input  logic [W-1:0] code,
  output logic [W-1:0] word,
  output logic         sout
);
  localparam int unsigned MSB = W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else begin
      unique case (acc)
        ACC_SER_OPEN: if (step) word <= {word[MSB-1:0], sin};
        ACC_SER_DONE: word <= word;
        default:      word <= code;
      endcase
    end
  end

  assign sout = word[MSB];
endmodule

// File: rtl/dly_setting_reg.sv
module dly_setting_reg
  import dly_set_pkg::*;
#(
  parameter int unsigned W = DEFAULT_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_par,
  input  logic         enable,
  input  logic [W-1:0] par_in,
  input  logic         ser_in,
  input  logic         ser_clk,
  output logic         ser_out,
  output logic [W-1:0] dly_code
);
  logic         en_prev;
  logic         sclk_prev;
  logic         sclk_rise;
  logic [W-1:0] chain_word;
  access_e      acc;

  dly_prev_bit u_en_prev (.clk(clk), .rst(rst), .d(enable),  .q(en_prev));
  dly_prev_bit u_sc_prev (.clk(clk), .rst(rst), .d(ser_clk), .q(sclk_prev));

  assign sclk_rise = ser_clk & ~sclk_prev;

  always_comb begin
    if (mode_par)     acc = enable ? ACC_PAR_OPEN : ACC_HOLD;
    else if (enable)  acc = ACC_SER_OPEN;
    else if (en_prev) acc = ACC_SER_DONE;
    else              acc = ACC_HOLD;
  end

  dly_code_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .acc(acc),
    .par_val(par_in), .chain_val(chain_word), .code(dly_code)
  );

  dly_shift_chain #(.W(W)) u_chain (
    .clk(clk), .rst(rst), .acc(acc), .step(sclk_rise), .sin(ser_in),
    .code(dly_code), .word(chain_word), .sout(ser_out)
  );
endmodule

// File: rtl/dly_setting_chk.sv
module dly_setting_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_par,
  input logic         enable,
  input logic [W-1:0] par_in,
  input logic         ser_out,
  input logic [W-1:0] dly_code
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (dly_code == '0) && !ser_out);

  a_r2_transparent_follow: assert property (@(posedge clk) disable iff (rst)
    (mode_par && enable) |=> dly_code == $past(par_in));

  a_r3_latched_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_par && !enable) |=> $stable(dly_code));

  a_r6_code_frozen_in_access: assert property (@(posedge clk) disable iff (rst)
    (!mode_par && enable) |=> $stable(dly_code));

  a_r10_idle_msb_visible: assert property (@(posedge clk) disable iff (rst)
    (!mode_par && !enable) |=> ser_out == dly_code[W-1]);
endmodule

bind dly_setting_reg dly_setting_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mode_par(mode_par), .enable(enable),
  .par_in(par_in), .ser_out(ser_out), .dly_code(dly_code)
);

// File: tb/tb_dly_setting_reg.sv
`timescale 1ns/1ps
module tb_dly_setting_reg;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic md = 1'b1, ae = 1'b0, sc = 1'b0, si = 1'b0;
  logic [W-1:0] p0 = '0, p1 = '0, p2 = '0;
  logic so0, so1, so2;
  logic [W-1:0] c0, c1, c2;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dly_setting_reg #(.W(W)) dut (.clk(clk), .rst(rst), .mode_par(md), .enable(ae),
    .par_in(p0), .ser_in(si), .ser_clk(sc), .ser_out(so0), .dly_code(c0));
  dly_setting_reg #(.W(W)) u1 (.clk(clk), .rst(rst), .mode_par(md), .enable(ae),
    .par_in(p1), .ser_in(so0), .ser_clk(sc), .ser_out(so1), .dly_code(c1));
  dly_setting_reg #(.W(W)) u2 (.clk(clk), .rst(rst), .mode_par(md), .enable(ae),
    .par_in(p2), .ser_in(so1), .ser_clk(sc), .ser_out(so2), .dly_code(c2));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_one(logic b);
    si = b; sc = 1'b1; tick();
    sc = 1'b0; tick();
  endtask

  task automatic t_reset;
    rst = 1'b1; tick(2); rst = 1'b0; tick();
    chk("R1 codes", {8'h0, c2, c1, c0}, 32'h0);
    chk("R1 ser_out", {29'h0, so2, so1, so0}, 32'h0);
  endtask

  task automatic t_transparent;
    md = 1'b1; ae = 1'b1;
    p0 = 8'hA5; p1 = 8'h3C; p2 = 8'h81; tick();
    chk("R2 follow", {8'h0, c2, c1, c0}, {8'h0, 8'h81, 8'h3C, 8'hA5});
    p0 = 8'h5A; tick();
    chk("R2 follow change", {24'h0, c0}, 32'h5A);
  endtask

  task automatic t_latched;
    p0 = 8'h17; tick();
    ae = 1'b0; p0 = 8'hEE; tick(3);
    chk("R3 hold after strobe", {24'h0, c0}, 32'h17);
    p0 = 8'h42; ae = 1'b1; tick(); ae = 1'b0; p0 = 8'h00; tick(2);
    chk("R3 capture pulse", {24'h0, c0}, 32'h42);
  endtask

  task automatic t_ignore_sc;
    md = 1'b0; ae = 1'b0; tick(2);
    for (int i = 0; i < 4; i++) shift_one(i[0]);
    chk("R9 codes kept", {8'h0, c2, c1, c0}, {8'h0, 8'h81, 8'h3C, 8'h42});
    chk("R10 ser_out msb", {29'h0, so2, so1, so0}, {29'h0, c2[7], c1[7], c0[7]});
  endtask

  task automatic do_write(logic [23:0] s);
    ae = 1'b1; tick();
    for (int i = 23; i >= 0; i--) shift_one(s[i]);
    ae = 1'b0; tick(2);
  endtask

  task automatic t_write24;
    logic [23:0] old;
    logic [23:0] s;
    old = {c2, c1, c0};
    s = 24'hC3_96_E1;
    ae = 1'b1; tick();
    chk("R4 msb before shift", {31'h0, so0}, {31'h0, old[7]});
    shift_one(s[23]);
    chk("R5 next lower bit", {31'h0, so0}, {31'h0, old[6]});
    chk("R6 frozen during access", {8'h0, c2, c1, c0}, {8'h0, old});
    for (int i = 22; i >= 0; i--) shift_one(s[i]);
    chk("R6 frozen after shifts", {8'h0, c2, c1, c0}, {8'h0, old});
    ae = 1'b0; tick(2);
    chk("R8 first byte in far unit", {8'h0, c2, c1, c0}, {8'h0, s});
  endtask

  task automatic t_readback;
    logic [23:0] exp, got;
    exp = {c2, c1, c0};
    got = '0;
    ae = 1'b1; tick();
    for (int i = 23; i >= 0; i--) begin
      got[i] = so2;
      shift_one(1'b0);
    end
    ae = 1'b0; tick(2);
    chk("R8 readback order", {8'h0, got}, {8'h0, exp});
    chk("R7 destructive read", {8'h0, c2, c1, c0}, 32'h0);
  endtask

  task automatic t_writeback;
    logic [23:0] s;
    s = 24'h5B_07_F0;
    do_write(s);
    ae = 1'b1; tick();
    for (int i = 0; i < 24; i++) shift_one(so2);
    ae = 1'b0; tick(2);
    chk("R7 write-back restores", {8'h0, c2, c1, c0}, {8'h0, s});
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_latched();
    t_ignore_sc();
    t_write24();
    t_readback();
    t_writeback();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule